// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Controller

This block gathers the interrupt events of a multi-channel DMA engine into three groups (transmit channels, receive channels and engine-level errors) and drives a single interrupt line toward the processor. Each event pulse from the datapath latches a sticky status bit at the position of its channel. Software decides which sources may reach the interrupt line through a per-group enable mask. The mask is never written directly: one register turns bits on and a second turns them off, so concurrent agents need no read-modify-write.

Software sees the block through a plain 32-bit register port, with write strobe, byte address and write data, and combinational read data. Each group offers a sticky status view, a view filtered by the mask, and the two mask update registers. Both update registers read back the current mask. A vector register reports every pending filtered source of all three groups in one word. An end-of-interrupt write with the same layout retires the selected status bits. Per-group acknowledge inputs let a nearby agent retire status bits without a bus access.

Top module: `irq_ctl`

## Requirements
- R1: After reset every status bit and every mask bit is zero and `irq` is low.
- R2: A high bit on `tx_evt`, `rx_evt` or `dma_evt` sets the status bit at the same index in its group at the next clock edge. The bit stays set until it is cleared, and no status bit sets without an event. Status reads at offset 0x80 (transmit), 0xA0 (receive) and 0xB0 (engine errors), with bit i belonging to channel i. The host-error source is engine bit 1.
- R3: Writing to the set register (0x88, 0xA8, 0xB8) turns on the mask bits written as one and leaves the bits written as zero unchanged. No other access changes the mask. Reads of the set and clear registers return the mask.
- R4: Writing to the clear register (0x8C, 0xAC, 0xBC) turns off the mask bits written as one. Writing all ones disables the whole group. The status bits are not changed.
- R5: The filtered status (0x84, 0xA4, 0xB4) reads as status AND mask.
- R6: `irq` is high exactly when any filtered status bit of any group is set.
- R7: A high bit on `tx_ack`, `rx_ack` or `dma_ack` clears the matching status bit at the next edge. When an event and any clear hit the same bit in the same cycle, the bit stays set.
- R8: Offset 0x90 reads the vector: transmit filtered bits at [NCH-1:0], receive at [2*NCH-1:NCH] and engine-error bits above them. Writes to status, filtered status and vector offsets have no effect.
- R9: A write to 0x94 clears every status bit whose position in the vector layout is written as one. The clear applies whatever the mask holds.
- R10: Offsets outside the map read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tx_evt | input | NCH | Transmit channel event pulses |
| rx_evt | input | NCH | Receive channel event pulses |
| dma_evt | input | NDMA | Engine-level error pulses |
| tx_ack | input | NCH | Transmit status clear pulses |
| rx_ack | input | NCH | Receive status clear pulses |
| dma_ack | input | NDMA | Engine error status clear pulses |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that inputs change only away from the clock edge and that a write lasts exactly the single cycle of its strobe. They also assume that only one register is addressed per cycle, so a set and a clear of the same group never coincide. The stimulus drives every input on the falling edge and drops strobes and pulses one cycle later. It issues one write or one pulse group at a time, except for the deliberate case where an event and an acknowledge land on the same bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned ADR_W = 8;

    localparam logic [ADR_W-1:0] TX_BASE  = 8'h80;
    localparam logic [ADR_W-1:0] RX_BASE  = 8'hA0;
    localparam logic [ADR_W-1:0] ERR_BASE = 8'hB0;

    localparam logic [ADR_W-1:0] OFS_STAT = 8'h00;
    localparam logic [ADR_W-1:0] OFS_FILT = 8'h04;
    localparam logic [ADR_W-1:0] OFS_ON   = 8'h08;
    localparam logic [ADR_W-1:0] OFS_OFF  = 8'h0C;

    localparam logic [ADR_W-1:0] ADR_VEC  = 8'h90;
    localparam logic [ADR_W-1:0] ADR_EOI  = 8'h94;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic         on_we,
    input  logic         off_we,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } grp_t;

    grp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // an event in the same cycle outlasts any clear
        st_d.stat = (st_q.stat & ~clr) | evt;
        if (on_we) begin
            st_d.mask = st_q.mask | wbits;
        end
        if (off_we) begin
            st_d.mask = st_d.mask & ~wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
    import irq_pkg::*;
#(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NDMA = 4,
    localparam int unsigned VW  = 2 * NCH + NDMA
) (
    input  logic [ADR_W-1:0] addr,
    input  logic [NCH-1:0]   tx_stat,
    input  logic [NCH-1:0]   tx_mask,
    input  logic [NCH-1:0]   rx_stat,
    input  logic [NCH-1:0]   rx_mask,
    input  logic [NDMA-1:0]  er_stat,
    input  logic [NDMA-1:0]  er_mask,
    input  logic [VW-1:0]    vec,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            TX_BASE  | OFS_STAT: rdata = REG_W'(tx_stat);
            TX_BASE  | OFS_FILT: rdata = REG_W'(tx_stat & tx_mask);
            TX_BASE  | OFS_ON,
            TX_BASE  | OFS_OFF:  rdata = REG_W'(tx_mask);
            RX_BASE  | OFS_STAT: rdata = REG_W'(rx_stat);
            RX_BASE  | OFS_FILT: rdata = REG_W'(rx_stat & rx_mask);
            RX_BASE  | OFS_ON,
            RX_BASE  | OFS_OFF:  rdata = REG_W'(rx_mask);
            ERR_BASE | OFS_STAT: rdata = REG_W'(er_stat);
            ERR_BASE | OFS_FILT: rdata = REG_W'(er_stat & er_mask);
            ERR_BASE | OFS_ON,
            ERR_BASE | OFS_OFF:  rdata = REG_W'(er_mask);
            ADR_VEC:             rdata = REG_W'(vec);
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_pkg::*;
#(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NDMA = 4,
    localparam int unsigned VW  = 2 * NCH + NDMA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [NCH-1:0]   tx_evt,
    input  logic [NCH-1:0]   rx_evt,
    input  logic [NDMA-1:0]  dma_evt,
    input  logic [NCH-1:0]   tx_ack,
    input  logic [NCH-1:0]   rx_ack,
    input  logic [NDMA-1:0]  dma_ack,
    output logic             irq
);
    logic [NCH-1:0]  tx_stat, tx_mask, rx_stat, rx_mask;
    logic [NDMA-1:0] er_stat, er_mask;
    logic [VW-1:0]   vec;
    logic [VW-1:0]   eoi_bits;
    logic            eoi_we;
    logic            wdata_spare;

    assign eoi_we      = wr_en && (addr == ADR_EOI);
    assign eoi_bits    = eoi_we ? wdata[VW-1:0] : '0;
    assign wdata_spare = ^wdata[REG_W-1:VW];

    irq_group #(.W(NCH)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (tx_evt),
        .clr    (tx_ack | eoi_bits[NCH-1:0]),
        .on_we  (wr_en && addr == (TX_BASE | OFS_ON)),
        .off_we (wr_en && addr == (TX_BASE | OFS_OFF)),
        .wbits  (wdata[NCH-1:0]),
        .stat   (tx_stat),
        .mask   (tx_mask)
    );

    irq_group #(.W(NCH)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (rx_evt),
        .clr    (rx_ack | eoi_bits[2*NCH-1:NCH]),
        .on_we  (wr_en && addr == (RX_BASE | OFS_ON)),
        .off_we (wr_en && addr == (RX_BASE | OFS_OFF)),
        .wbits  (wdata[NCH-1:0]),
        .stat   (rx_stat),
        .mask   (rx_mask)
    );

    irq_group #(.W(NDMA)) u_er (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (dma_evt),
        .clr    (dma_ack | eoi_bits[VW-1:2*NCH]),
        .on_we  (wr_en && addr == (ERR_BASE | OFS_ON)),
        .off_we (wr_en && addr == (ERR_BASE | OFS_OFF)),
        .wbits  (wdata[NDMA-1:0]),
        .stat   (er_stat),
        .mask   (er_mask)
    );

    assign vec = {er_stat & er_mask, rx_stat & rx_mask, tx_stat & tx_mask};
    assign irq = |vec;

    irq_rdmux #(.NCH(NCH), .NDMA(NDMA)) u_rd (
        .addr    (addr),
        .tx_stat (tx_stat),
        .tx_mask (tx_mask),
        .rx_stat (rx_stat),
        .rx_mask (rx_mask),
        .er_stat (er_stat),
        .er_mask (er_mask),
        .vec     (vec),
        .rdata   (rdata)
    );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NDMA = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      addr,
    input logic [31:0]     wdata,
    input logic [NCH-1:0]  tx_evt,
    input logic [NDMA-1:0] dma_evt,
    input logic [NCH-1:0]  tx_stat,
    input logic [NCH-1:0]  tx_mask,
    input logic [NCH-1:0]  rx_stat,
    input logic [NCH-1:0]  rx_mask,
    input logic [NDMA-1:0] er_stat,
    input logic [NDMA-1:0] er_mask,
    input logic            irq
);
    AST_TX_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt != '0) |=> ((tx_stat & $past(tx_evt)) == $past(tx_evt))); // R2
    AST_ERR_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt != '0) |=> ((er_stat & $past(dma_evt)) == $past(dma_evt))); // R2
    AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tx_stat & ~$past(tx_stat) & ~$past(tx_evt)) == '0)); // R2
    AST_TX_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 8'h88 || addr == 8'h8C)) |=> $stable(tx_mask)); // R3
    AST_RX_OFF_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'hAC && wdata == 32'hFFFF_FFFF) |=> (rx_mask == '0)); // R4
    AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((|(tx_stat & tx_mask)) || (|(rx_stat & rx_mask)) || (|(er_stat & er_mask)))); // R6
endmodule

bind irq_ctl irq_ctl_chk #(.NCH(NCH), .NDMA(NDMA)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tx_evt  (tx_evt),
    .dma_evt (dma_evt),
    .tx_stat (tx_stat),
    .tx_mask (tx_mask),
    .rx_stat (rx_stat),
    .rx_mask (rx_mask),
    .er_stat (er_stat),
    .er_mask (er_mask),
    .irq     (irq)
);

// File: tb/irq_ctl_test.sv
`timescale 1ns/1ps
module irq_ctl_test;
    localparam int NCH  = 8;
    localparam int NDMA = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  tx_evt = '0, rx_evt = '0, tx_ack = '0, rx_ack = '0;
    logic [NDMA-1:0] dma_evt = '0, dma_ack = '0;
    logic            irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    irq_ctl #(.NCH(NCH), .NDMA(NDMA)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_evt(tx_evt), .rx_evt(rx_evt), .dma_evt(dma_evt),
        .tx_ack(tx_ack), .rx_ack(rx_ack), .dma_ack(dma_ack), .irq(irq)
    );

    // monitor: compares queued expectations shortly before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = sb.pop_front();
                got = it.is_irq ? {31'b0, irq} : rdata;
                n_chk++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a;
        sb.push_back('{0, e, tag});
    endtask

    task automatic chk_irq(input bit e, input string tag);
        @(negedge clk);
        sb.push_back('{1, {31'b0, e}, tag});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [NCH-1:0] te, input logic [NCH-1:0] re,
                         input logic [NDMA-1:0] de, input logic [NCH-1:0] ta,
                         input logic [NCH-1:0] ra, input logic [NDMA-1:0] da);
        @(negedge clk);
        tx_evt = te; rx_evt = re; dma_evt = de; tx_ack = ta; rx_ack = ra; dma_ack = da;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; dma_evt = '0; tx_ack = '0; rx_ack = '0; dma_ack = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h80, 32'h0, "R1 tx status");
        rd(8'h88, 32'h0, "R1 tx mask");
        rd(8'hA0, 32'h0, "R1 rx status");
        rd(8'hBC, 32'h0, "R1 err mask");
        chk_irq(0, "R1 irq low");
        // R2 event latch, masked off
        pulse(8'h05, 0, 0, 0, 0, 0);
        rd(8'h80, 32'h05, "R2 tx status");
        rd(8'h84, 32'h00, "R5 filtered with empty mask");
        chk_irq(0, "R6 irq masked off");
        // R3 set register
        wr(8'h88, 32'h04);
        rd(8'h88, 32'h04, "R3 mask via set reg");
        rd(8'h8C, 32'h04, "R3 mask via clear reg");
        rd(8'h84, 32'h04, "R5 filtered");
        chk_irq(1, "R6 irq tx");
        wr(8'h88, 32'h00);
        rd(8'h88, 32'h04, "R3 zero write keeps mask");
        // R2 host error bit
        pulse(0, 0, 4'b0010, 0, 0, 0);
        rd(8'hB0, 32'h02, "R2 host error status");
        wr(8'hB8, 32'h02);
        rd(8'hB4, 32'h02, "R5 err filtered");
        // R4 clear all
        wr(8'h8C, 32'hFFFF_FFFF);
        rd(8'h88, 32'h00, "R4 tx mask cleared");
        chk_irq(1, "R6 irq from err group");
        wr(8'hBC, 32'hFFFF_FFFF);
        chk_irq(0, "R6 irq all off");
        rd(8'h80, 32'h05, "R4 status untouched");
        // R7 acknowledge and collision
        pulse(0, 0, 0, 8'h01, 0, 0);
        rd(8'h80, 32'h04, "R7 ack clears");
        pulse(8'h04, 0, 0, 8'h04, 0, 0);
        rd(8'h80, 32'h04, "R7 event wins over ack");
        pulse(0, 0, 0, 8'h04, 0, 0);
        rd(8'h80, 32'h00, "R7 ack alone clears");
        // R8 vector
        pulse(0, 8'h80, 0, 0, 0, 0);
        wr(8'hA8, 32'hFF);
        rd(8'hA4, 32'h80, "R5 rx filtered");
        rd(8'h90, 32'h0000_8000, "R8 vector rx only");
        wr(8'hB8, 32'h02);
        rd(8'h90, 32'h0002_8000, "R8 vector rx and err");
        wr(8'h80, 32'hFF);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'hA4, 32'h00);
        rd(8'h80, 32'h00, "R8 status write ignored");
        rd(8'h90, 32'h0002_8000, "R8 vector write ignored");
        // R9 end of interrupt
        wr(8'h94, 32'h0000_8000);
        rd(8'hA0, 32'h00, "R9 eoi clears rx");
        rd(8'hB0, 32'h02, "R9 eoi spares err");
        chk_irq(1, "R9 irq still from err");
        wr(8'h94, 32'h0002_0000);
        rd(8'hB0, 32'h00, "R9 eoi clears err");
        chk_irq(0, "R9 irq low");
        // R10 unmapped
        rd(8'h40, 32'h0, "R10 unmapped read");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule